// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a 64-word by 16-bit nonvolatile word store. A host reaches it over a three-wire synchronous link: a select line, a serial clock and a data-in line, plus a data-out line with its own output enable. The host raises select and clocks in a start bit of 1, a two-bit opcode and a six-bit address. Data-in is taken on rising serial clock edges. The block then reads a word, writes or erases one word, fills every word, or sets or clears a programming-enable latch.

The serial pins are resynchronised into the system clock domain. Programming is self-timed by a counter of `PROG_CYCLES` system clocks. While that counter runs the block is busy and ignores new instructions. A host polls for completion by dropping select for at least `MIN_DESEL` system clocks and raising it again. The data-out line then shows 0 while the cycle runs and 1 once the block is ready. The two whole-array instructions also need a supply-valid input flag to be high.

Top module: `ee_serial_slave`

## Requirements
- R1: An instruction starts at the first 1 clocked in after select is raised; zeros before it are ignored. Opcode 10 reads, 01 writes and 11 erases. Opcode 00 picks a special command from the top two address bits: 11 enables programming, 00 disables it, 10 erases the whole array and 01 writes the whole array. All fields are sent MSB first.
- R2: After reset the programming-enable latch is clear, and write or erase instructions leave the array unchanged until an enable instruction has run.
- R3: Once set, the enable latch stays set until a disable instruction or a reset, and after a disable, writes leave the array unchanged.
- R4: A read is accepted whatever the state of the enable latch. Data-out is enabled and shows a 0 dummy bit once the last address bit is taken. The 16 data bits follow MSB first, one per later rising serial clock edge.
- R5: A write stores its 16 data bits into the addressed word. Programming begins after the last data bit.
- R6: Erase sets every bit of the addressed word to 1, and erase-all sets every word to all ones.
- R7: Write-all stores its 16-bit data word into all 64 locations.
- R8: Select may be held low for at least `MIN_DESEL` clocks and then raised after a programming instruction. Data-out is then enabled and shows 0 while the cycle runs and 1 once it has ended. Data-out is disabled whenever select is low.
- R9: Erase-all and write-all change nothing while the supply-valid input is low.
- R10: Dropping select before an instruction is complete aborts it with no change to the array.
- R11: While a programming cycle runs, any instruction sent is ignored.
- R12: After reset, data-out is disabled and every word reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| supply_ok | input | 1 | Supply-valid flag for whole-array instructions |
| dout | output | 1 | Serial data out or ready/busy status |
| dout_oe | output | 1 | Output enable for dout |

## Verification
Some rules are checked on every cycle. No programming request is issued while a cycle is running. Whole-array requests appear only with the supply flag high. Data-out is disabled after select goes low. A read opens with a low dummy bit. Status shown during a busy cycle is 0. Other behaviour needs the bench's instruction sequences. These cover the stored contents after writes, erases and fills, and writes ignored while disabled, after a disable, after a reset or while busy. They also cover aborted instructions, leading zeros before the start bit, and the change of the status from busy to ready.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [1:0] {
    K_WRITE = 2'd0,
    K_ERASE = 2'd1,
    K_ERAL  = 2'd2,
    K_WRAL  = 2'd3
  } prog_kind_e;

  localparam logic [1:0] OPC_SPECIAL = 2'b00;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_ERASE   = 2'b11;

  localparam logic [1:0] SUB_DISABLE = 2'b00;
  localparam logic [1:0] SUB_FILL    = 2'b01;
  localparam logic [1:0] SUB_CLEAR   = 2'b10;
  localparam logic [1:0] SUB_ENABLE  = 2'b11;
endpackage

// File: rtl/ee_in_sync.sv
module ee_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise,
  output logic cs_rise
);
  logic [STAGES-1:0] cs_sr, sk_sr, di_sr;
  logic              sk_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr <= '0;
      sk_sr <= '0;
      di_sr <= '0;
      sk_d  <= 1'b0;
      cs_d  <= 1'b0;
    end else begin
      cs_sr <= {cs_sr[STAGES-2:0], cs};
      sk_sr <= {sk_sr[STAGES-2:0], sk};
      di_sr <= {di_sr[STAGES-2:0], di};
      sk_d  <= sk_sr[STAGES-1];
      cs_d  <= cs_sr[STAGES-1];
    end
  end

  assign cs_s    = cs_sr[STAGES-1];
  assign di_s    = di_sr[STAGES-1];
  assign sk_rise = sk_sr[STAGES-1] & ~sk_d;
  assign cs_rise = cs_sr[STAGES-1] & ~cs_d;
endmodule

// File: rtl/ee_store.sv
module ee_store
  import ee_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  prog_kind_e        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);

  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              busy_q, busy_d;
  prog_kind_e        kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              commit;
  logic [DATA_W-1:0] mem_q [WORDS];

  assign commit = busy_q && (tmr_q == '0);

  always_comb begin
    tmr_d  = tmr_q;
    busy_d = busy_q;
    kind_d = kind_q;
    addr_d = addr_q;
    data_d = data_q;
    if (busy_q) begin
      if (commit) busy_d = 1'b0;
      else        tmr_d  = tmr_q - 1'b1;
    end else if (req) begin
      busy_d = 1'b1;
      tmr_d  = TMR_W'(PROG_CYCLES - 1);
      kind_d = kind;
      addr_d = addr;
      data_d = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      busy_q <= 1'b0;
      kind_q <= K_WRITE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      tmr_q  <= tmr_d;
      busy_q <= busy_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic              we;
    logic [DATA_W-1:0] wval;
    always_comb begin
      we   = 1'b0;
      wval = '1;
      if (commit) begin
        unique case (kind_q)
          K_WRITE: begin we = (addr_q == ADDR_W'(w)); wval = data_q; end
          K_ERASE: begin we = (addr_q == ADDR_W'(w)); wval = '1;     end
          K_ERAL:  begin we = 1'b1;                   wval = '1;     end
          K_WRAL:  begin we = 1'b1;                   wval = data_q; end
        endcase
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[w] <= '1;
      else if (we) mem_q[w] <= wval;
    end
  end

  assign rd_data = mem_q[rd_addr];
  assign busy    = busy_q;
endmodule

// File: rtl/ee_cmd_decoder.sv
module ee_cmd_decoder
  import ee_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int MIN_DESEL = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              cs_rise,
  input  logic              sk_rise,
  input  logic              di_s,
  input  logic              supply_ok,
  input  logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              prog_req,
  output prog_kind_e        prog_kind,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              status_show,
  output logic              rd_active
);
  localparam int HDR_W  = 2 + ADDR_W;
  localparam int MAXB   = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W  = $clog2(MAXB + 1);
  localparam int DS_W   = $clog2(MIN_DESEL + 1);
  localparam logic [DS_W-1:0] DS_MAX = DS_W'(MIN_DESEL);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_READ, S_DONE} state_e;

  state_e            st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HDR_W-1:0]  hdr_q, hdr_d, hdr_sh;
  logic [DATA_W-1:0] dat_q, dat_d, dat_sh;
  logic [DATA_W-1:0] rsr_q, rsr_d;
  logic              en_q, en_d;
  logic              show_q, show_d;
  logic              pend_q, pend_d;
  logic [DS_W-1:0]   ds_q, ds_d;
  logic              dout_q, dout_d, oe_q, oe_d;
  logic              req_q, req_d;
  prog_kind_e        kind_q, kind_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic [DATA_W-1:0] pdata_q, pdata_d;
  logic [1:0]        opc_new, opc_held, sub_new;

  assign hdr_sh   = {hdr_q[HDR_W-2:0], di_s};
  assign dat_sh   = {dat_q[DATA_W-2:0], di_s};
  assign opc_new  = hdr_sh[HDR_W-1 -: 2];
  assign sub_new  = hdr_sh[ADDR_W-1 -: 2];
  assign opc_held = hdr_q[HDR_W-1 -: 2];
  assign rd_addr  = hdr_sh[ADDR_W-1:0];

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    hdr_d   = hdr_q;
    dat_d   = dat_q;
    rsr_d   = rsr_q;
    en_d    = en_q;
    show_d  = show_q;
    pend_d  = pend_q;
    ds_d    = ds_q;
    dout_d  = 1'b0;
    oe_d    = 1'b0;
    req_d   = 1'b0;
    kind_d  = kind_q;
    paddr_d = paddr_q;
    pdata_d = pdata_q;
    if (!cs_s) begin
      st_d   = S_IDLE;
      cnt_d  = '0;
      show_d = 1'b0;
      if (ds_q != DS_MAX) ds_d = ds_q + 1'b1;
    end else begin
      ds_d = '0;
      if (cs_rise && (ds_q == DS_MAX) && pend_q) show_d = 1'b1;
      unique case (st_q)
        S_IDLE: begin
          oe_d   = show_q;
          dout_d = show_q & ~busy;
          if (sk_rise && di_s && !busy) begin
            st_d   = S_HDR;
            cnt_d  = '0;
            show_d = 1'b0;
            pend_d = 1'b0;
            oe_d   = 1'b0;
            dout_d = 1'b0;
          end
        end
        S_HDR: begin
          if (sk_rise) begin
            hdr_d = hdr_sh;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(HDR_W - 1)) begin
              cnt_d = '0;
              st_d  = S_DONE;
              unique case (opc_new)
                OPC_READ: begin
                  st_d   = S_READ;
                  rsr_d  = rd_data;
                  oe_d   = 1'b1;
                  dout_d = 1'b0;
                end
                OPC_WRITE: st_d = S_DATA;
                OPC_ERASE: begin
                  if (en_q) begin
                    req_d   = 1'b1;
                    kind_d  = K_ERASE;
                    paddr_d = hdr_sh[ADDR_W-1:0];
                  end
                end
                OPC_SPECIAL: begin
                  unique case (sub_new)
                    SUB_ENABLE:  en_d = 1'b1;
                    SUB_DISABLE: en_d = 1'b0;
                    SUB_CLEAR: begin
                      if (en_q && supply_ok) begin
                        req_d  = 1'b1;
                        kind_d = K_ERAL;
                      end
                    end
                    SUB_FILL: st_d = S_DATA;
                  endcase
                end
              endcase
            end
          end
        end
        S_DATA: begin
          if (sk_rise) begin
            dat_d = dat_sh;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              st_d    = S_DONE;
              pdata_d = dat_sh;
              paddr_d = hdr_q[ADDR_W-1:0];
              if (opc_held == OPC_WRITE && en_q) begin
                req_d  = 1'b1;
                kind_d = K_WRITE;
              end else if (opc_held == OPC_SPECIAL && en_q && supply_ok) begin
                req_d  = 1'b1;
                kind_d = K_WRAL;
              end
            end
          end
        end
        S_READ: begin
          oe_d   = 1'b1;
          dout_d = dout_q;
          if (sk_rise) begin
            dout_d = rsr_q[DATA_W-1];
            rsr_d  = {rsr_q[DATA_W-2:0], 1'b0};
          end
        end
        default: ;
      endcase
      if (req_d) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      dat_q   <= '0;
      rsr_q   <= '0;
      en_q    <= 1'b0;
      show_q  <= 1'b0;
      pend_q  <= 1'b0;
      ds_q    <= '0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
      req_q   <= 1'b0;
      kind_q  <= K_WRITE;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      hdr_q   <= hdr_d;
      dat_q   <= dat_d;
      rsr_q   <= rsr_d;
      en_q    <= en_d;
      show_q  <= show_d;
      pend_q  <= pend_d;
      ds_q    <= ds_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
      req_q   <= req_d;
      kind_q  <= kind_d;
      paddr_q <= paddr_d;
      pdata_q <= pdata_d;
    end
  end

  assign prog_req    = req_q;
  assign prog_kind   = kind_q;
  assign prog_addr   = paddr_q;
  assign prog_data   = pdata_q;
  assign dout        = dout_q;
  assign dout_oe     = oe_q;
  assign status_show = show_q;
  assign rd_active   = (st_q == S_READ);
endmodule

// File: rtl/ee_serial_slave.sv
module ee_serial_slave
  import ee_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 2000,
  parameter int MIN_DESEL   = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic supply_ok,
  output logic dout,
  output logic dout_oe
);
  logic [1:0]        rst_sync;
  logic              rst_ni;
  logic              cs_s, di_s, sk_rise, cs_rise;
  logic              busy, prog_req, status_show, rd_active;
  prog_kind_e        prog_kind;
  logic [ADDR_W-1:0] prog_addr, rd_addr;
  logic [DATA_W-1:0] prog_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  ee_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .cs(cs), .sk(sk), .di(di),
    .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise), .cs_rise(cs_rise)
  );

  ee_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_DESEL(MIN_DESEL)) u_dec (
    .clk(clk), .rst_n(rst_ni), .cs_s(cs_s), .cs_rise(cs_rise),
    .sk_rise(sk_rise), .di_s(di_s), .supply_ok(supply_ok), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data), .prog_req(prog_req),
    .prog_kind(prog_kind), .prog_addr(prog_addr), .prog_data(prog_data),
    .dout(dout), .dout_oe(dout_oe), .status_show(status_show),
    .rd_active(rd_active)
  );

  ee_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_ni), .req(prog_req), .kind(prog_kind),
    .addr(prog_addr), .data(prog_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );
endmodule

// File: rtl/ee_serial_chk.sv
module ee_serial_chk
  import ee_pkg::*;
(
  input logic       clk,
  input logic       rst_ni,
  input logic       cs_s,
  input logic       busy,
  input logic       prog_req,
  input prog_kind_e prog_kind,
  input logic       supply_ok,
  input logic       dout,
  input logic       dout_oe,
  input logic       status_show,
  input logic       rd_active
);
  p_no_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> !prog_req);

  p_bulk_supply_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (prog_req && (prog_kind == K_ERAL || prog_kind == K_WRAL)) |-> $past(supply_ok));

  p_status_busy_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (status_show && busy) |=> !dout);

  p_oe_off_desel_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !cs_s |=> !dout_oe);

  p_dummy_bit_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rd_active) |-> (dout_oe && !dout));
endmodule

bind ee_serial_slave ee_serial_chk u_chk (
  .clk(clk), .rst_ni(rst_ni), .cs_s(cs_s), .busy(busy),
  .prog_req(prog_req), .prog_kind(prog_kind), .supply_ok(supply_ok),
  .dout(dout), .dout_oe(dout_oe), .status_show(status_show),
  .rd_active(rd_active)
);

// File: tb/tb_ee_serial_slave.sv
module tb_ee_serial_slave;
  localparam int HALF_SK    = 8;
  localparam int DESEL_WAIT = 20;
  localparam int NVEC       = 10;
  // entry: {op[1:0], addr[5:0], data[15:0]}; op 0 write, 1 read-check, 2 erase
  localparam logic [23:0] VEC [NVEC] = '{
    24'h00A5C3, 24'h3F8001, 24'h110000, 24'h40A5C3, 24'h7F8001,
    24'h510000, 24'hBF0000, 24'h7FFFFF, 24'h051234, 24'h451234
  };

  logic clk = 1'b0;
  logic rst_n, cs, sk, di, supply_ok;
  logic dout, dout_oe;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  ee_serial_slave #(.PROG_CYCLES(600)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .supply_ok(supply_ok), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clk_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    di = b;
    clk_wait(HALF_SK);
    sk = 1'b1;
    clk_wait(HALF_SK);
    sk = 1'b0;
  endtask

  task automatic select();
    cs = 1'b0;
    clk_wait(DESEL_WAIT);
    cs = 1'b1;
    clk_wait(4);
  endtask

  task automatic send_hdr(input logic [1:0] opc, input logic [5:0] a);
    sk_bit(1'b1);
    for (int i = 1; i >= 0; i--) sk_bit(opc[i]);
    for (int i = 5; i >= 0; i--) sk_bit(a[i]);
  endtask

  task automatic send_data(input logic [15:0] d, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) sk_bit(d[i]);
  endtask

  task automatic do_read(input logic [5:0] a, input int lead0, output logic [15:0] v, output logic dummy_ok);
    select();
    for (int i = 0; i < lead0; i++) sk_bit(1'b0);
    send_hdr(2'b10, a);
    dummy_ok = dout_oe && !dout;
    v = '0;
    for (int i = 0; i < 16; i++) begin
      sk_bit(1'b0);
      v = {v[14:0], dout};
    end
    cs = 1'b0;
  endtask

  task automatic do_special(input logic [1:0] sub, input logic [15:0] d);
    select();
    send_hdr(2'b00, {sub, 4'b0000});
    if (sub == 2'b01) send_data(d, 16);
    cs = 1'b0;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d);
    select();
    send_hdr(2'b01, a);
    send_data(d, 16);
    cs = 1'b0;
  endtask

  task automatic do_erase(input logic [5:0] a);
    select();
    send_hdr(2'b11, a);
    cs = 1'b0;
  endtask

  // R8: status after a programming instruction: 0 while busy, then 1
  task automatic wait_ready();
    bit seen;
    select();
    clk_wait(2);
    chk(dout_oe && !dout, "R8 busy status", {14'd0, dout_oe, dout}, 16'h0002);
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (dout_oe && dout) seen = 1'b1;
    end
    chk(seen, "R8 ready status", {15'd0, seen}, 16'h0001);
    cs = 1'b0;
  endtask

  task automatic read_chk(input logic [5:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    logic        dok;
    do_read(a, 0, v, dok);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    cs = 1'b0; sk = 1'b0; di = 1'b0;
    clk_wait(5);
    rst_n = 1'b1;
    clk_wait(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic        dok;
    supply_ok = 1'b1;
    apply_reset();

    // R12: reset state
    chk(!dout_oe, "R12 dout_oe after reset", {15'd0, dout_oe}, 16'h0000);
    do_read(6'd0, 0, v, dok);
    chk(v == 16'hFFFF, "R12 word 0 after reset", v, 16'hFFFF);
    // R4: dummy bit ahead of read data
    chk(dok, "R4 dummy bit 0 with output enabled", {15'd0, dok}, 16'h0001);

    // R2: programming disabled after reset
    do_write(6'd5, 16'h1234);
    read_chk(6'd5, 16'hFFFF, "R2 write ignored while disabled");
    do_erase(6'd5);
    read_chk(6'd5, 16'hFFFF, "R2 erase leaves word");

    do_special(2'b11, 16'h0);

    // Table walk: R5 writes, R4 reads, R6 erase
    for (int k = 0; k < NVEC; k++) begin
      logic [1:0]  op;
      logic [5:0]  a;
      logic [15:0] d;
      op = VEC[k][23:22];
      a  = VEC[k][21:16];
      d  = VEC[k][15:0];
      case (op)
        2'd0: begin do_write(a, d); wait_ready(); end
        2'd1: read_chk(a, d, "R5 R6 R4 vector read");
        2'd2: begin do_erase(a); wait_ready(); end
        default: ;
      endcase
    end

    // R1: leading zeros before the start bit
    do_read(6'd0, 3, v, dok);
    chk(v == 16'hA5C3, "R1 leading zeros ignored", v, 16'hA5C3);

    // R10: abort in the middle of the data field
    select();
    send_hdr(2'b01, 6'd5);
    send_data(16'h0000, 8);
    cs = 1'b0;
    clk_wait(700);
    read_chk(6'd5, 16'h1234, "R10 aborted write");

    // R11: instruction while busy is ignored
    do_write(6'd20, 16'h1111);
    do_write(6'd21, 16'h2222);
    wait_ready();
    read_chk(6'd20, 16'h1111, "R11 first write lands");
    read_chk(6'd21, 16'hFFFF, "R11 write during busy ignored");

    // R7: write-all
    do_special(2'b01, 16'h3C3C);
    wait_ready();
    read_chk(6'd0,  16'h3C3C, "R7 fill word 0");
    read_chk(6'd63, 16'h3C3C, "R7 fill word 63");
    read_chk(6'd40, 16'h3C3C, "R7 fill word 40");

    // R9: whole-array instructions blocked without supply flag
    supply_ok = 1'b0;
    do_special(2'b10, 16'h0);
    clk_wait(700);
    read_chk(6'd0, 16'h3C3C, "R9 erase-all blocked");
    do_special(2'b01, 16'h0F0F);
    clk_wait(700);
    read_chk(6'd9, 16'h3C3C, "R9 write-all blocked");
    supply_ok = 1'b1;

    // R6: erase-all
    do_special(2'b10, 16'h0);
    wait_ready();
    read_chk(6'd0,  16'hFFFF, "R6 erase-all word 0");
    read_chk(6'd63, 16'hFFFF, "R6 erase-all word 63");

    // R3: disable blocks writes
    do_write(6'd7, 16'h5555);
    wait_ready();
    read_chk(6'd7, 16'h5555, "R3 write while enabled");
    do_special(2'b00, 16'h0);
    do_write(6'd7, 16'hAAAA);
    clk_wait(700);
    read_chk(6'd7, 16'h5555, "R3 write after disable ignored");

    // R2/R12: reset clears the enable latch
    do_special(2'b11, 16'h0);
    apply_reset();
    do_write(6'd8, 16'h7777);
    clk_wait(700);
    read_chk(6'd8, 16'hFFFF, "R2 enable cleared by reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule